// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the byte that follows a START condition on an I2C bus is addressed to this slave. A front-end block assembles the byte and presents it together with a one-cycle valid strobe. The matcher compares the byte against two configuration registers and reports the result on a one-cycle match pulse. It also sets a sticky interrupt flag, loads a direction flag, raises a general-call indicator and shows a 10-bit-prefix indicator.

The primary register holds the slave address in bits [7:1], and its bit 0 enables general call. The secondary register holds seven more bits in [7:1] plus a mode bit in bit 0. When the mode bit is 0, the seven bits act as a don't-care mask on the primary address. When the mode bit is 1, they form a second complete address. A match-all input makes every strobed byte match, whatever the registers hold. Bus sampling, START/STOP detection, acknowledge generation and checking of the second byte of a 10-bit address belong to other blocks.

Top module: `i2c_addr_matcher`

## Requirements
- R1: With the secondary register at 0x00, a strobed byte matches when its bits [7:1] equal bits [7:1] of the primary register, whatever the value of its bit 0.
- R2: With secondary bit 0 at 0, each 1 in secondary bits [7:1] makes the corresponding byte bit compare as equal, and unmasked bits must still agree with the primary register.
- R3: With secondary bit 0 at 1, a byte matches when its bits [7:1] equal either the primary bits [7:1] or the secondary bits [7:1], and no masking applies.
- R4: With primary bit 0 at 1, the byte 0x00 matches and gcall_o goes to 1. With primary bit 0 at 0, the byte 0x00 only matches through R1 to R3 or R6, and gcall_o then stays 0.
- R5: On a match of a byte whose bits [7:3] are 11110, ten_bit_o goes to 1 and ten_hi_o takes byte bits [2:1]. On a match of any other byte, ten_bit_o goes to 0.
- R6: While match_all_i is 1, every strobed byte matches, whatever the registers hold.
- R7: match_o is 1 for exactly the one cycle after a clock edge at which addr_vld_i was 1 and the byte matched. A byte presented without the strobe never produces a match.
- R8: irq_o is set by a match and stays at 1 until irq_clr_i is sampled at 1. If a match and a clear occur at the same edge, the set wins.
- R9: A match loads dir_o from byte bit 0 (1 = read). A strobe without a match leaves dir_o, gcall_o, ten_bit_o and ten_hi_o unchanged.
- R10: After reset both registers hold 0x00 and all outputs are 0. A register write takes effect for strobes from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| own_we_i | input | 1 | Write enable, primary register |
| own_wd_i | input | 8 | Write data: [7:1] address, [0] general-call enable |
| alt_we_i | input | 1 | Write enable, secondary register |
| alt_wd_i | input | 8 | Write data: [7:1] mask or second address, [0] mode (1 = second address) |
| match_all_i | input | 1 | Match every address |
| addr_vld_i | input | 1 | Strobe: addr_byte_i holds a received address byte |
| addr_byte_i | input | 8 | Received address byte, bit 0 = R/W |
| irq_clr_i | input | 1 | Clears irq_o |
| match_o | output | 1 | One-cycle match pulse |
| irq_o | output | 1 | Sticky address interrupt flag |
| dir_o | output | 1 | R/W bit of the last matched byte |
| gcall_o | output | 1 | Last match was a general call |
| ten_bit_o | output | 1 | Last match was a 10-bit prefix |
| ten_hi_o | output | 2 | Upper two bits of the 10-bit address from the last match |

## Verification
The hardest case to reach is a strobe that fails to match while earlier results are still present. This matters because R9 requires the stored flags to keep their values through such a strobe. The stimulus first matches a read byte to leave dir_o and irq_o at 1. It then strobes a non-matching byte, checks that nothing moved, and only afterwards exercises the clear and the simultaneous set-and-clear. Each table vector reprograms both registers one cycle before its strobe and pulses the clear together with the strobe. As a result, the expected interrupt value equals the expected match value, independent of earlier vectors.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  // Width of the address field inside a received byte
  localparam int unsigned ADDR_W_DEF   = 7;
  // Leading bits that mark the first byte of a 10-bit address
  localparam int unsigned PREFIX_W_DEF = 5;
  localparam logic [PREFIX_W_DEF-1:0] PREFIX_DEF = 5'b11110;

  typedef struct packed {
    logic       hit;
    logic       gcall;
    logic       ten;
    logic [1:0] ten_hi;
  } match_res_t;

endpackage

// File: rtl/i2c_am_rst_sync.sv
module i2c_am_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/i2c_am_cfg_reg.sv
module i2c_am_cfg_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (we_i) begin
      val_d = wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  assign q_o = val_q;

endmodule

// File: rtl/i2c_am_compare.sv
module i2c_am_compare #(
  parameter int unsigned          ADDR_W   = 7,
  parameter int unsigned          PREFIX_W = 5,
  parameter logic [PREFIX_W-1:0]  PREFIX   = 5'b11110
) (
  input  logic [ADDR_W:0]            byte_i,
  input  logic [ADDR_W:0]            own_i,
  input  logic [ADDR_W:0]            alt_i,
  input  logic                       match_all_i,
  output logic                       hit_o,
  output logic                       gcall_o,
  output logic                       ten_o,
  output logic [ADDR_W-PREFIX_W-1:0] ten_hi_o
);

  localparam int unsigned HI_W = ADDR_W - PREFIX_W;

  logic              dual_mode;
  logic [ADDR_W-1:0] prim_eq;
  logic [ADDR_W-1:0] sec_eq;
  logic              prim_hit;
  logic              sec_hit;
  logic              gc_hit;

  assign dual_mode = alt_i[0];

  // One comparator slice per address bit
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    logic masked;
    assign masked     = ~dual_mode & alt_i[i+1];
    assign prim_eq[i] = (byte_i[i+1] == own_i[i+1]) | masked;
    assign sec_eq[i]  = (byte_i[i+1] == alt_i[i+1]);
  end

  assign prim_hit = &prim_eq;
  assign sec_hit  = dual_mode & (&sec_eq);
  assign gc_hit   = own_i[0] & (byte_i == '0);

  assign hit_o    = match_all_i | prim_hit | sec_hit | gc_hit;
  assign gcall_o  = gc_hit;
  assign ten_o    = (byte_i[ADDR_W -: PREFIX_W] == PREFIX);
  assign ten_hi_o = byte_i[HI_W:1];

endmodule

// File: rtl/i2c_am_flags.sv
module i2c_am_flags #(
  parameter int unsigned HI_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic            hit_i,
  input  logic            gcall_i,
  input  logic            ten_i,
  input  logic [HI_W-1:0] ten_hi_i,
  input  logic            rw_i,
  input  logic            clr_i,
  output logic            match_o,
  output logic            irq_o,
  output logic            dir_o,
  output logic            gcall_o,
  output logic            ten_o,
  output logic [HI_W-1:0] ten_hi_o
);

  logic            take;
  logic            match_q, match_d;
  logic            irq_q,   irq_d;
  logic            dir_q,   dir_d;
  logic            gc_q,    gc_d;
  logic            ten_q,   ten_d;
  logic [HI_W-1:0] hi_q,    hi_d;

  assign take = vld_i & hit_i;

  always_comb begin
    match_d = take;
    irq_d   = irq_q;
    if (clr_i) begin
      irq_d = 1'b0;
    end
    if (take) begin
      irq_d = 1'b1;
    end
    dir_d = dir_q;
    gc_d  = gc_q;
    ten_d = ten_q;
    hi_d  = hi_q;
    if (take) begin
      dir_d = rw_i;
      gc_d  = gcall_i;
      ten_d = ten_i;
      hi_d  = ten_i ? ten_hi_i : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      irq_q   <= 1'b0;
      dir_q   <= 1'b0;
      gc_q    <= 1'b0;
      ten_q   <= 1'b0;
      hi_q    <= '0;
    end else begin
      match_q <= match_d;
      irq_q   <= irq_d;
      dir_q   <= dir_d;
      gc_q    <= gc_d;
      ten_q   <= ten_d;
      hi_q    <= hi_d;
    end
  end

  assign match_o  = match_q;
  assign irq_o    = irq_q;
  assign dir_o    = dir_q;
  assign gcall_o  = gc_q;
  assign ten_o    = ten_q;
  assign ten_hi_o = hi_q;

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
#(
  parameter int unsigned         ADDR_W   = ADDR_W_DEF,
  parameter int unsigned         PREFIX_W = PREFIX_W_DEF,
  parameter logic [PREFIX_W-1:0] PREFIX   = PREFIX_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       own_we_i,
  input  logic [ADDR_W:0]            own_wd_i,
  input  logic                       alt_we_i,
  input  logic [ADDR_W:0]            alt_wd_i,
  input  logic                       match_all_i,
  input  logic                       addr_vld_i,
  input  logic [ADDR_W:0]            addr_byte_i,
  input  logic                       irq_clr_i,
  output logic                       match_o,
  output logic                       irq_o,
  output logic                       dir_o,
  output logic                       gcall_o,
  output logic                       ten_bit_o,
  output logic [ADDR_W-PREFIX_W-1:0] ten_hi_o
);

  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned HI_W   = ADDR_W - PREFIX_W;

  logic              rst_sync_n;
  logic [BYTE_W-1:0] own_q;
  logic [BYTE_W-1:0] alt_q;
  logic              cmp_hit;
  logic              cmp_gc;
  logic              cmp_ten;
  logic [HI_W-1:0]   cmp_hi;

  i2c_am_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  i2c_am_cfg_reg #(.W(BYTE_W)) u_own (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .we_i   (own_we_i),
    .wd_i   (own_wd_i),
    .q_o    (own_q)
  );

  i2c_am_cfg_reg #(.W(BYTE_W)) u_alt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .we_i   (alt_we_i),
    .wd_i   (alt_wd_i),
    .q_o    (alt_q)
  );

  i2c_am_compare #(
    .ADDR_W   (ADDR_W),
    .PREFIX_W (PREFIX_W),
    .PREFIX   (PREFIX)
  ) u_cmp (
    .byte_i      (addr_byte_i),
    .own_i       (own_q),
    .alt_i       (alt_q),
    .match_all_i (match_all_i),
    .hit_o       (cmp_hit),
    .gcall_o     (cmp_gc),
    .ten_o       (cmp_ten),
    .ten_hi_o    (cmp_hi)
  );

  i2c_am_flags #(.HI_W(HI_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .vld_i    (addr_vld_i),
    .hit_i    (cmp_hit),
    .gcall_i  (cmp_gc),
    .ten_i    (cmp_ten),
    .ten_hi_i (cmp_hi),
    .rw_i     (addr_byte_i[0]),
    .clr_i    (irq_clr_i),
    .match_o  (match_o),
    .irq_o    (irq_o),
    .dir_o    (dir_o),
    .gcall_o  (gcall_o),
    .ten_o    (ten_bit_o),
    .ten_hi_o (ten_hi_o)
  );

endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              match_all_i,
  input logic              addr_vld_i,
  input logic [BYTE_W-1:0] addr_byte_i,
  input logic              irq_clr_i,
  input logic              match_o,
  input logic              irq_o,
  input logic              dir_o,
  input logic              gcall_o
);

  assert_match_all_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (addr_vld_i && match_all_i) |=> match_o);

  assert_no_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !addr_vld_i |=> !match_o);

  assert_irq_set_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    match_o |-> irq_o);

  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  assert_dir_load_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    addr_vld_i |=> (!match_o || (dir_o == $past(addr_byte_i[0]))));

  assert_gcall_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    addr_vld_i |=> (!match_o || !gcall_o || ($past(addr_byte_i) == '0)));

endmodule

bind i2c_addr_matcher i2c_am_checker #(.BYTE_W(ADDR_W + 1)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .match_all_i (match_all_i),
  .addr_vld_i  (addr_vld_i),
  .addr_byte_i (addr_byte_i),
  .irq_clr_i   (irq_clr_i),
  .match_o     (match_o),
  .irq_o       (irq_o),
  .dir_o       (dir_o),
  .gcall_o     (gcall_o)
);

// File: tb/tb_i2c_addr_matcher.sv
module tb_i2c_addr_matcher;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       own_we_i, alt_we_i;
  logic [7:0] own_wd_i, alt_wd_i;
  logic       match_all_i, addr_vld_i, irq_clr_i;
  logic [7:0] addr_byte_i;
  logic       match_o, irq_o, dir_o, gcall_o, ten_bit_o;
  logic [1:0] ten_hi_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  i2c_addr_matcher dut (
    .clk_i, .rst_ni, .own_we_i, .own_wd_i, .alt_we_i, .alt_wd_i,
    .match_all_i, .addr_vld_i, .addr_byte_i, .irq_clr_i,
    .match_o, .irq_o, .dir_o, .gcall_o, .ten_bit_o, .ten_hi_o
  );

  // {own, alt, match_all, byte, match, dir, gcall, ten, ten_hi}
  localparam int NV = 18;
  localparam logic [30:0] VECS [0:NV-1] = '{
    {8'hA0, 8'h00, 1'b0, 8'hA0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00}, // R1
    {8'hA0, 8'h00, 1'b0, 8'hA1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00}, // R1
    {8'hA0, 8'h00, 1'b0, 8'hA2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00}, // R1
    {8'hA0, 8'h06, 1'b0, 8'hA6, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00}, // R2
    {8'hA0, 8'h06, 1'b0, 8'hA7, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00}, // R2
    {8'hA0, 8'h06, 1'b0, 8'hA8, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00}, // R2
    {8'hA0, 8'h67, 1'b0, 8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00}, // R3
    {8'hA0, 8'h67, 1'b0, 8'hA1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00}, // R3
    {8'hA0, 8'h67, 1'b0, 8'hA6, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00}, // R3
    {8'hA1, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00}, // R4
    {8'hA0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00}, // R4
    {8'hF4, 8'h00, 1'b0, 8'hF4, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10}, // R5
    {8'hF4, 8'h00, 1'b0, 8'hF5, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10}, // R5
    {8'hF4, 8'h00, 1'b0, 8'hF2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00}, // R5
    {8'hA0, 8'h00, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00}, // R6
    {8'hA0, 8'h00, 1'b1, 8'hF0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00}, // R6
    {8'hA0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00}, // R6
    {8'hA0, 8'hFE, 1'b0, 8'h12, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00}  // R2
  };
  localparam string VREQ [0:NV-1] = '{
    "R1", "R1", "R1", "R2", "R2", "R2", "R3", "R3", "R3",
    "R4", "R4", "R5", "R5", "R5", "R6", "R6", "R6", "R2"
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Program both registers; they are in effect from the next cycle
  task automatic cfg(input logic [7:0] own, input logic [7:0] alt);
    @(negedge clk_i);
    own_we_i = 1'b1; own_wd_i = own;
    alt_we_i = 1'b1; alt_wd_i = alt;
    @(negedge clk_i);
    own_we_i = 1'b0; alt_we_i = 1'b0;
  endtask

  // Strobe a byte at one edge, leaving the outputs ready to sample at the next negedge
  task automatic strobe(input logic [7:0] b, input logic clr);
    addr_byte_i = b; addr_vld_i = 1'b1; irq_clr_i = clr;
    @(negedge clk_i);
    addr_vld_i = 1'b0; irq_clr_i = 1'b0;
  endtask

  initial begin
    #(5ns * 20000);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_ni = 1'b0;
    own_we_i = 1'b0; alt_we_i = 1'b0; own_wd_i = '0; alt_wd_i = '0;
    match_all_i = 1'b0; addr_vld_i = 1'b0; addr_byte_i = '0; irq_clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R10: outputs at reset
    chk("R10", "outputs after reset",
        {2'b0, match_o, irq_o, dir_o, gcall_o, ten_bit_o, |ten_hi_o}, 8'h00);

    // R10: registers reset to zero, so address 0 matches with a read bit
    strobe(8'h01, 1'b0);
    chk("R10", "match with reset regs", {7'b0, match_o}, 8'h01);
    chk("R10", "dir with reset regs", {7'b0, dir_o}, 8'h01);
    chk("R10", "gcall with reset regs", {7'b0, gcall_o}, 8'h00);

    // R7: pulse lasts one cycle
    @(negedge clk_i);
    chk("R7", "match after one cycle", {7'b0, match_o}, 8'h00);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VECS[i];
      match_all_i = v[14];
      cfg(v[30:23], v[22:15]);
      strobe(v[13:6], 1'b1);
      chk(VREQ[i], $sformatf("match vec %0d", i), {7'b0, match_o}, {7'b0, v[5]});
      chk("R8", $sformatf("irq vec %0d", i), {7'b0, irq_o}, {7'b0, v[5]});
      if (v[5]) begin
        chk("R9", $sformatf("dir vec %0d", i), {7'b0, dir_o}, {7'b0, v[4]});
        chk(VREQ[i], $sformatf("gcall vec %0d", i), {7'b0, gcall_o}, {7'b0, v[3]});
        chk(VREQ[i], $sformatf("ten vec %0d", i), {5'b0, ten_bit_o, ten_hi_o}, {5'b0, v[2:0]});
      end
      @(negedge clk_i);
      chk("R7", $sformatf("pulse end vec %0d", i), {7'b0, match_o}, 8'h00);
    end
    match_all_i = 1'b0;

    // R7: byte on the bus without strobe
    cfg(8'hA0, 8'h00);
    addr_byte_i = 8'hA0;
    @(negedge clk_i);
    chk("R7", "no strobe no match", {7'b0, match_o}, 8'h00);

    // R9 / R8: hold through a non-matching strobe
    strobe(8'hA1, 1'b1);
    chk("R9", "dir loaded", {7'b0, dir_o}, 8'h01);
    strobe(8'hA2, 1'b0);
    chk("R9", "dir held on miss", {7'b0, dir_o}, 8'h01);
    chk("R8", "irq held on miss", {7'b0, irq_o}, 8'h01);
    repeat (2) @(negedge clk_i);
    chk("R8", "irq sticky", {7'b0, irq_o}, 8'h01);
    irq_clr_i = 1'b1;
    @(negedge clk_i);
    irq_clr_i = 1'b0;
    chk("R8", "irq cleared", {7'b0, irq_o}, 8'h00);

    // R8: set wins over clear at the same edge
    strobe(8'hA0, 1'b1);
    chk("R8", "set beats clear", {7'b0, irq_o}, 8'h01);
    chk("R9", "dir write", {7'b0, dir_o}, 8'h00);

    // R10: write takes effect next cycle
    cfg(8'h20, 8'h00);
    strobe(8'h21, 1'b0);
    chk("R10", "new address", {7'b0, match_o}, 8'h01);
    @(negedge clk_i);
    strobe(8'hA0, 1'b0);
    chk("R10", "old address gone", {7'b0, match_o}, 8'h00);

    summary();
  end

endmodule